// File: doc/BRIEF.md
# Overflow-Aligned 8-Bit PWM Generator

This block drives one pulse-width-modulated pin from an 8-bit up-counter. The counter advances on a prescaled tick taken from the system clock, so one output period lasts 256 ticks. Each active phase starts when the counter wraps from 0xFF to 0x00 and ends when the counter reaches the programmed compare value. Software sets the compare value, the active polarity, an output gate, a run bit and the tick ratio through a single synchronous write port. All five fields are loaded together on the clock edge where `cfg_we` is high.

A state machine in `pwm8_fsm` sets the waveform. It has four states. ST_IDLE means the block is stopped. ST_WAIT runs from start until the first wrap. ST_ACTIVE covers the active phase and ST_INACTIVE the rest of each period. The transitions are:
- T_START: ST_IDLE to ST_WAIT, when running.
- T_WRAP_ON: ST_WAIT, ST_ACTIVE or ST_INACTIVE to ST_ACTIVE, at a wrap with a nonzero compare value.
- T_WRAP_OFF: to ST_INACTIVE, at a wrap with a compare value of zero.
- T_MATCH: ST_ACTIVE to ST_INACTIVE, when the counter steps onto the compare value.
- T_STOP: any state to ST_IDLE, when the run bit is clear. T_STOP has the highest priority.

The compare value should be rewritten no more often than once every three ticks.

Top module: `pwm8_gen`

## Requirements
- R1: After reset, `pwm_out` is 0. The polarity, output-enable and run fields all reset to 0.
- R2: The tick ratio is selected by `cfg_sel`. Values 0, 1, 2 and 3 give one tick every P = 1, 2, 4 or 8 system clocks. The output period is 256·P clocks.
- R3: Let E be the edge that sets the run bit from the stopped state. The pin holds the inactive level for the first 256·P clocks after E, until the first counter wrap.
- R4: From each wrap, the pin shows the active level for N·P clocks, where N is `cfg_cmp`. It then shows the inactive level until the next wrap.
- R5: With N = 0 the pin stays at the inactive level for the whole period.
- R6: With `cfg_pol` = 0 the active level is 1 and the inactive level is 0. With `cfg_pol` = 1 the levels are reversed.
- R7: With `cfg_oe` = 0 the pin drives the inactive level, which equals `cfg_pol`, at all times.
- R8: Clearing the run bit makes the pin inactive from that write edge onward, including on an edge where a wrap would occur. It also returns the counter to 0x00, so a later start repeats the R3 wait.
- R9: A new compare value written while running, at a point where the counter has already passed both values, sets the active width of the following periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads all configuration fields on this edge |
| cfg_cmp | input | 8 | Compare value N, the active width in ticks |
| cfg_pol | input | 1 | 0 = active high, 1 = active low |
| cfg_oe | input | 1 | 1 = waveform on pin, 0 = pin held at the inactive level |
| cfg_run | input | 1 | 1 = count, 0 = stop and clear |
| cfg_sel | input | 2 | Tick ratio select: P = 2^cfg_sel |
| pwm_out | output | 1 | PWM pin |

## Verification
Two cases make functions fall in the same cycle. In the first, the compare value is zero: the wrap and the match both happen on the wrap tick, and the wrap must win with an inactive result, so the pin must stay inactive over several whole periods. In the second, the run bit is cleared by a write timed to land exactly on the wrap edge at ratio 2, so the stop and the switch to the active level collide, and the pin must stay inactive on every following sample. The sweeps compare the pin on every clock against an arithmetic model of the start time, the ratio and N.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT     = 2'd1,
        ST_ACTIVE   = 2'd2,
        ST_INACTIVE = 2'd3
    } pwm_state_e;

endpackage

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NUM_SEL = 1 << SEL_W;
    localparam int DIV_W   = (NUM_SEL > 1) ? NUM_SEL - 1 : 1;
    localparam logic [DIV_W-1:0] DIV_ONE = 1;
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_SEL - 1);

    logic [DIV_W-1:0]   div_q;
    logic [NUM_SEL-1:0] tick_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!run)
            div_q <= '0;
        else
            div_q <= div_q + DIV_ONE;
    end

    generate
        for (genvar i = 0; i < NUM_SEL; i++) begin : g_ratio
            if (i == 0) begin : g_full
                assign tick_vec[i] = 1'b1;
            end else begin : g_div
                assign tick_vec[i] = &div_q[i-1:0];
            end
        end
    endgenerate

    assign tick = run & tick_vec[sel];

    // R2: at the slowest ratio two ticks never fall on adjacent clocks
    a_r2_slow_ratio_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == SEL_MAX && NUM_SEL > 1) |=> (!tick || sel != SEL_MAX));

    // R2: stopped means no tick
    a_r2_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    output logic             wrap,
    output logic             hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt_q + CNT_ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_nxt;
    end

    assign wrap = tick & (cnt_q == CNT_MAX);
    assign hit  = tick & (cnt_nxt == cmp);

    // R2: a wrap tick lands the counter on zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap) |=> (cnt_q == '0));

    // R2: without a tick the count holds
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q));

    // R8: stopping clears the count
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/pwm8_fsm.sv
module pwm8_fsm
    import pwm8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wrap,
    input  logic hit,
    input  logic cmp_zero,
    output logic act
);
    pwm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_IDLE;                       // T_STOP
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_WAIT;          // T_START
                ST_WAIT, ST_INACTIVE: begin
                    if (wrap)
                        state_d = cmp_zero ? ST_INACTIVE : ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (wrap)
                        state_d = cmp_zero ? ST_INACTIVE : ST_ACTIVE;
                    else if (hit)
                        state_d = ST_INACTIVE;       // T_MATCH
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        act = (state_q == ST_ACTIVE) && run;
    end

    // R3: leaving idle always passes through the wait state
    a_r3_start_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && run) |=> (state_q == ST_WAIT || !run));

    // R3: the wait state never reports an active phase
    a_r3_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !act);

    // R4: a wrap with nonzero compare opens the active phase
    a_r4_wrap_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap && !cmp_zero) |=> (state_q == ST_ACTIVE || !run));

    // R5: a zero compare never opens an active phase at a wrap
    a_r5_zero_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap && cmp_zero) |=> (state_q != ST_ACTIVE));

    // R8: a cleared run bit parks the machine
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state_q == ST_IDLE));

endmodule

// File: rtl/pwm8_gen.sv
module pwm8_gen #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_cmp,
    input  logic             cfg_pol,
    input  logic             cfg_oe,
    input  logic             cfg_run,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic             pwm_out
);
    logic [CNT_W-1:0] cmp_q;
    logic             pol_q;
    logic             oe_q;
    logic             run_q;
    logic [SEL_W-1:0] sel_q;
    logic             tick;
    logic             wrap;
    logic             hit;
    logic             act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            pol_q <= 1'b0;
            oe_q  <= 1'b0;
            run_q <= 1'b0;
            sel_q <= '0;
        end else if (cfg_we) begin
            cmp_q <= cfg_cmp;
            pol_q <= cfg_pol;
            oe_q  <= cfg_oe;
            run_q <= cfg_run;
            sel_q <= cfg_sel;
        end
    end

    pwm8_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .sel   (sel_q),
        .tick  (tick)
    );

    pwm8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .tick  (tick),
        .cmp   (cmp_q),
        .wrap  (wrap),
        .hit   (hit)
    );

    pwm8_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .wrap     (wrap),
        .hit      (hit),
        .cmp_zero (cmp_q == '0),
        .act      (act)
    );

    assign pwm_out = (oe_q & act) ^ pol_q;

    // R7: with the gate closed the pin sits at the inactive level
    a_r7_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_q |-> (pwm_out == pol_q));

endmodule

// File: tb/tb_pwm8_gen.sv
`timescale 1ns/1ps
module tb_pwm8_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_cmp = '0;
    logic       cfg_pol = 1'b0;
    logic       cfg_oe = 1'b0;
    logic       cfg_run = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic       pwm_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pwm8_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cmp(cfg_cmp),
        .cfg_pol(cfg_pol), .cfg_oe(cfg_oe), .cfg_run(cfg_run),
        .cfg_sel(cfg_sel), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input logic act, input logic exp, input int t);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0d pwm_out=%b expected=%b", req, t, act, exp);
        end
    endtask

    function automatic logic model(int t, int p, int n, logic pol, logic oe, bit stopped);
        bit active;
        active = !stopped && (t >= 256*p) && (((t - 256*p) % (256*p)) < n*p);
        return (oe & active) ^ pol;
    endfunction

    task automatic drive(input logic [7:0] n, input logic pol, input logic oe,
                         input logic run, input logic [1:0] sel);
        cfg_we = 1'b1; cfg_cmp = n; cfg_pol = pol; cfg_oe = oe;
        cfg_run = run; cfg_sel = sel;
    endtask

    // mode 0: plain run; 1: stop at evt; 2: rewrite compare to new_n at evt
    task automatic run_seq(input string req, input int sel, input int n0,
                           input logic pol, input logic oe, input int last_t,
                           input int mode, input int evt, input int new_n);
        int  p;
        int  n;
        bit  stopped;
        p = 1 << sel;
        n = n0;
        stopped = 0;
        drive(8'(n0), pol, oe, 1'b0, 2'(sel));
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        drive(8'(n0), pol, oe, 1'b1, 2'(sel));
        @(negedge clk);
        for (int t = 0; t <= last_t; t++) begin
            cfg_we = 1'b0;
            if (mode == 1 && t == evt + 1) stopped = 1;
            if (mode == 2 && t == evt + 1) n = new_n;
            check(req, pwm_out, model(t, p, n, pol, oe, stopped), t);
            if (t == evt && mode == 1) drive(8'(n), pol, oe, 1'b0, 2'(sel));
            if (t == evt && mode == 2) drive(8'(new_n), pol, oe, 1'b1, 2'(sel));
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", pwm_out, 1'b0, -1);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1", pwm_out, 1'b0, -1);
        end
        // R3 R4 R5 at full rate, sweep of compare values incl. bounds
        run_seq("R5", 0, 0,   1'b0, 1'b1, 768, 0, -1, 0);
        run_seq("R4", 0, 1,   1'b0, 1'b1, 768, 0, -1, 0);
        run_seq("R4", 0, 2,   1'b0, 1'b1, 768, 0, -1, 0);
        run_seq("R3", 0, 128, 1'b0, 1'b1, 768, 0, -1, 0);
        run_seq("R4", 0, 255, 1'b0, 1'b1, 768, 0, -1, 0);
        // R2 every tick ratio
        run_seq("R2", 1, 3,   1'b0, 1'b1, 1100, 0, -1, 0);
        run_seq("R2", 2, 77,  1'b0, 1'b1, 2100, 0, -1, 0);
        run_seq("R2", 3, 255, 1'b0, 1'b1, 4200, 0, -1, 0);
        run_seq("R2", 3, 1,   1'b0, 1'b1, 4200, 0, -1, 0);
        // R6 active-low polarity
        run_seq("R6", 0, 40,  1'b1, 1'b1, 600, 0, -1, 0);
        run_seq("R6", 1, 200, 1'b1, 1'b1, 1100, 0, -1, 0);
        // R7 gate closed, both polarities
        run_seq("R7", 0, 40,  1'b0, 1'b0, 600, 0, -1, 0);
        run_seq("R7", 0, 40,  1'b1, 1'b0, 600, 0, -1, 0);
        // R8 stop during active phase, then restart repeats the wait
        run_seq("R8", 0, 100, 1'b0, 1'b1, 340, 1, 300, 0);
        run_seq("R8", 0, 100, 1'b1, 1'b1, 600, 0, -1, 0);
        // R8 stop landing on the wrap edge at ratio 2
        run_seq("R8", 1, 200, 1'b0, 1'b1, 560, 1, 511, 0);
        // R9 compare rewrite while inactive
        run_seq("R9", 0, 10,  1'b0, 1'b1, 800, 2, 356, 50);
        run_seq("R9", 2, 20,  1'b1, 1'b1, 2200, 2, 1500, 3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule